// File: doc/BRIEF.md
# Energy Dispersal Descrambler

This block undoes the pseudo-random energy-dispersal scrambling applied to a byte stream of fixed-length transport packets. The stream reaching it has already been decoded and aligned, so each byte comes with a packet-start strobe and, once every eight packets, a group-start strobe. Every payload byte is XORed with eight bits from a 15-stage linear feedback shift register. The register uses the polynomial 1 + x^14 + x^15.

The first sync byte of a group is sent inverted. When it arrives, the register is loaded with a fixed seed and the byte is replaced by the normal sync value. The other seven sync bytes of the group pass through as they are. The register still advances by eight bits on each of them, so the sequence stays aligned with the payload. Cycles with the valid flag low leave the generator and the output valid flag unchanged.

A bypass control copies the input straight to the output, while the generator keeps its normal sequence. Each output byte appears one clock after the input byte that produced it.

Top module: `prbs_descrambler`

## Requirements
- R1: While reset is held, and afterwards, `out_valid` equals the value `in_valid` had one clock earlier. During reset `out_valid` is 0 and `out_byte` is 0x00.
- R2: A valid byte with `pkt_start` low is a payload byte. Its output is the input XORed with the next eight generator bits. The first bit generated goes to bit 7 and the last to bit 0.
- R3: Each generator step outputs the XOR of stages 14 and 15. That bit is shifted into stage 1 and every other stage takes the value of the stage below it. With all-zero payload, the first byte after a group start therefore comes out as 0x03.
- R4: A valid byte with `pkt_start` and `grp_start` both high loads the seed into the generator. Stages 1 to 15 of the seed read 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0. Unless bypass is set, the output is the sync value 0x47, whatever the input byte is. The group start is normally the inverted sync 0xB8.
- R5: A valid byte with `pkt_start` high and `grp_start` low is output unchanged. The generator still advances by eight steps on that byte.
- R6: A cycle with `in_valid` low does not advance the generator and does not produce an output byte, even if strobes are present. A `grp_start` without `pkt_start` is treated as a payload byte.
- R7: While `bypass` is high, every valid byte is output unchanged, including group-start bytes. The generator advances or reloads exactly as it would without bypass.
- R8: A group start received part-way through a group reloads the seed at once. The payload that follows uses the sequence from its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming byte |
| in_valid | input | 1 | `in_byte` holds a byte this cycle |
| pkt_start | input | 1 | Byte is the sync byte of a packet |
| grp_start | input | 1 | Sync byte opens an eight-packet group (inverted sync) |
| bypass | input | 1 | Pass bytes through unchanged |
| out_byte | output | 8 | Descrambled byte |
| out_valid | output | 1 | `out_byte` holds a byte this cycle |

## Verification
The first group is sent with all-zero payload. This shows the raw key stream, so a wrong seed, wrong taps or reversed bit order give a different first byte than 0x03. Random payload with idle cycles mixed in, and strobes raised on idle cycles, shows whether the generator advances only on valid bytes. Bypass is entered in the middle of a packet and on a group-start byte; the bytes after bypass ends show whether the generator kept its sequence. A group restarted after three packets, and a group strobe raised without a packet strobe, show that the seed is reloaded only when both strobes come with a valid sync byte.

// File: rtl/prbs_descr_pkg.sv
package prbs_descr_pkg;

   typedef enum logic [1:0] {
      KIND_IDLE    = 2'd0,
      KIND_PAYLOAD = 2'd1,
      KIND_SYNC    = 2'd2,
      KIND_GROUP   = 2'd3
   } byte_kind_e;

   function automatic byte_kind_e classify_byte(input logic vld,
                                                input logic pkt,
                                                input logic grp);
      byte_kind_e k;
      if (!vld)
         k = KIND_IDLE;
      else if (pkt && grp)
         k = KIND_GROUP;
      else if (pkt)
         k = KIND_SYNC;
      else
         k = KIND_PAYLOAD;
      return k;
   endfunction

endpackage

// File: rtl/prbs_byte_gen.sv
module prbs_byte_gen #(
   parameter int          LFSR_LEN = 15,
   parameter int          TAP_HI   = 15,
   parameter int          TAP_LO   = 14,
   parameter int          STEPS    = 8,
   parameter logic [14:0] SEED     = 15'h00A9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                advance,
   input  logic                reload,
   output logic [STEPS-1:0]    key_o,
   output logic [LFSR_LEN-1:0] state_o
);

   localparam int HI_IDX = TAP_HI - 1;
   localparam int LO_IDX = TAP_LO - 1;
   localparam logic [LFSR_LEN-1:0] SEED_V = LFSR_LEN'(SEED);

   logic [LFSR_LEN-1:0] st_q;
   logic [STEPS:0][LFSR_LEN-1:0] chain;

   assign chain[0] = st_q;

   generate
      for (genvar k = 0; k < STEPS; k++) begin : g_step
         logic fb;
         assign fb            = chain[k][HI_IDX] ^ chain[k][LO_IDX];
         assign chain[k+1]    = {chain[k][LFSR_LEN-2:0], fb};
         assign key_o[STEPS-1-k] = fb;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= SEED_V;
      else if (reload)
         st_q <= SEED_V;
      else if (advance)
         st_q <= chain[STEPS];
   end

   assign state_o = st_q;

   // R3: a non-zero seed with this feedback can never reach the all-zero lock-up state
   assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != '0);

endmodule

// File: rtl/prbs_descr_out.sv
module prbs_descr_out #(
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  SYNC_BYTE = 8'h47,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  prbs_descr_pkg::byte_kind_e    kind,
   input  logic [DATA_W-1:0]             din,
   input  logic [DATA_W-1:0]             key,
   input  logic                          bypass,
   output logic [DATA_W-1:0]             dout,
   output logic                          dvalid
);
   import prbs_descr_pkg::*;

   localparam logic [DATA_W-1:0] SYNC_V = DATA_W'(SYNC_BYTE);

   logic                byp_eff;
   logic [DATA_W-1:0]   nxt;

   generate
      if (BYPASS_EN) begin : g_byp
         assign byp_eff = bypass;
      end else begin : g_nobyp
         logic unused_byp;
         assign unused_byp = bypass;
         assign byp_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt = din;
      if (!byp_eff) begin
         unique case (kind)
            KIND_GROUP:   nxt = SYNC_V;
            KIND_PAYLOAD: nxt = din ^ key;
            default:      nxt = din;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout   <= '0;
         dvalid <= 1'b0;
      end else begin
         dvalid <= (kind != KIND_IDLE);
         if (kind != KIND_IDLE)
            dout <= nxt;
      end
   end

   // R5: plain sync bytes leave the block untouched
   assert_sync_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == KIND_SYNC) |=> (dout == $past(din)));

endmodule

// File: rtl/prbs_descrambler.sv
module prbs_descrambler #(
   parameter int          DATA_W    = 8,
   parameter int          LFSR_LEN  = 15,
   parameter int          TAP_HI    = 15,
   parameter int          TAP_LO    = 14,
   parameter logic [14:0] SEED      = 15'h00A9,
   parameter logic [7:0]  SYNC_BYTE = 8'h47,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              in_valid,
   input  logic              pkt_start,
   input  logic              grp_start,
   input  logic              bypass,
   output logic [DATA_W-1:0] out_byte,
   output logic              out_valid
);
   import prbs_descr_pkg::*;

   localparam logic [LFSR_LEN-1:0] SEED_V = LFSR_LEN'(SEED);
   localparam logic [DATA_W-1:0]   SYNC_V = DATA_W'(SYNC_BYTE);

   generate
      if (LFSR_LEN < 2 || LFSR_LEN > 15)
         $error("LFSR_LEN out of range");
      if (TAP_HI > LFSR_LEN || TAP_LO < 1 || TAP_LO >= TAP_HI)
         $error("tap positions invalid");
      if (DATA_W < 1 || DATA_W > 8)
         $error("DATA_W out of range");
      if (SEED_V == '0)
         $error("seed must be non-zero");
   endgenerate

   byte_kind_e          kind;
   logic [DATA_W-1:0]   key;
   logic [LFSR_LEN-1:0] gen_state;

   assign kind = classify_byte(in_valid, pkt_start, grp_start);

   prbs_byte_gen #(
      .LFSR_LEN (LFSR_LEN),
      .TAP_HI   (TAP_HI),
      .TAP_LO   (TAP_LO),
      .STEPS    (DATA_W),
      .SEED     (SEED)
   ) gen_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (kind == KIND_PAYLOAD || kind == KIND_SYNC),
      .reload  (kind == KIND_GROUP),
      .key_o   (key),
      .state_o (gen_state)
   );

   prbs_descr_out #(
      .DATA_W    (DATA_W),
      .SYNC_BYTE (SYNC_BYTE),
      .BYPASS_EN (BYPASS_EN)
   ) out_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind   (kind),
      .din    (in_byte),
      .key    (key),
      .bypass (bypass),
      .dout   (out_byte),
      .dvalid (out_valid)
   );

   // R1: one-cycle latency of the valid flag
   assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R4: group start reloads the seed
   assert_group_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pkt_start && grp_start) |=> (gen_state == SEED_V));

   // R4: group start byte comes out as the normal sync value
   assert_group_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pkt_start && grp_start && !bypass) |=> (out_byte == SYNC_V));

   // R6: idle cycles freeze the generator
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(gen_state));

   // R7: bypass copies valid bytes
   assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bypass) |=> (out_byte == $past(in_byte)));

endmodule

// File: tb/prbs_descrambler_tb.sv
`timescale 1ns/100ps
module prbs_descrambler_tb_top;

   localparam int PAY_LEN = 11;

   typedef struct {
      bit         v;
      logic [7:0] b;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_byte = '0;
   logic       in_valid = 1'b0;
   logic       pkt_start = 1'b0;
   logic       grp_start = 1'b0;
   logic       bypass = 1'b0;
   logic [7:0] out_byte;
   logic       out_valid;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   exp_t q[$];
   bit [15:1] rs = 15'b000000010101001;  // model register, index = stage

   always #2.5 clk = ~clk;

   prbs_descrambler dut_i (
      .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
      .pkt_start(pkt_start), .grp_start(grp_start), .bypass(bypass),
      .out_byte(out_byte), .out_valid(out_valid)
   );

   task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: one byte per call, expected result pushed to the scoreboard
   task automatic send(logic [7:0] d, bit v, bit ps, bit gs, bit byp,
                       string tag, int force_exp = -1);
      exp_t e;
      logic [7:0] ks = '0;
      @(negedge clk);
      in_byte = d; in_valid = v; pkt_start = ps; grp_start = gs; bypass = byp;
      e.v = v; e.b = 8'h00; e.tag = tag;
      if (v) begin
         if (ps && gs) begin
            rs  = 15'b000000010101001;   // stage1=1, stage4, stage6, stage8
            e.b = byp ? d : 8'h47;
         end else begin
            for (int k = 0; k < 8; k++) begin
               bit nb;
               nb = rs[14] ^ rs[15];
               rs = {rs[14:1], nb};
               ks = {ks[6:0], nb};
            end
            e.b = (byp || ps) ? d : (d ^ ks);
         end
         if (force_exp >= 0) e.b = 8'(force_exp);
      end
      q.push_back(e);
   endtask

   task automatic packet(bit grp, bit zero_pay, bit gaps, int byp_from, string ptag);
      send(grp ? 8'hB8 : 8'h47, 1, 1, grp, 1'b0, grp ? "R4" : "R5");
      for (int i = 0; i < PAY_LEN; i++) begin
         logic [7:0] d;
         bit byp;
         d   = zero_pay ? 8'h00 : 8'($urandom);
         byp = (byp_from >= 0) && (i >= byp_from) && (i < byp_from + 3);
         if (grp && zero_pay && i == 0)
            send(d, 1, 0, 0, 0, "R3", 8'h03);
         else
            send(d, 1, 0, 0, byp, byp ? "R7" : ptag);
         if (gaps && (i % 2 == 0))
            send(8'hB8, 0, 1, 1, 0, "R6");
      end
   endtask

   // monitor: one scoreboard entry per clock, sampled after the edge
   initial begin
      @(posedge rst_n);
      forever begin
         @(posedge clk); #1;
         if (done) break;
         if (q.size() == 0) begin
            check(out_valid == 1'b0, "R1", 8'(out_valid), 8'h00);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(out_valid == e.v, "R1", 8'(out_valid), 8'(e.v));
            if (e.v)
               check(out_byte == e.b, e.tag, out_byte, e.b);
         end
      end
   end

   // watchdog
   initial begin
      #(5ns * 20000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R1", 8'(out_valid), 8'h00);
      check(out_byte == 8'h00, "R1", out_byte, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // group 1: zero payload exposes the raw key stream
      for (int p = 0; p < 8; p++) packet(p == 0, 1'b1, 1'b0, -1, "R2");
      // group 2: random payload, idle gaps, bypass mid packet
      for (int p = 0; p < 8; p++) packet(p == 0, 1'b0, p == 2, (p == 4) ? 3 : -1, "R2");
      // stray group strobe without packet strobe is plain payload
      send(8'h5A, 1, 0, 1, 0, "R6");
      // bypass on a plain sync byte and on a group-start byte
      send(8'h47, 1, 1, 0, 1, "R7");
      for (int i = 0; i < 4; i++) send(8'($urandom), 1, 0, 0, 0, "R2");
      send(8'hB8, 1, 1, 1, 1, "R7");
      for (int i = 0; i < PAY_LEN; i++) send(8'($urandom), 1, 0, 0, 0, "R7");
      // restart of the group after three packets
      for (int p = 0; p < 3; p++) packet(p == 0, 1'b0, 1'b0, -1, "R2");
      packet(1'b1, 1'b1, 1'b0, -1, "R8");
      for (int p = 0; p < 7; p++) packet(1'b0, 1'b0, 1'b0, -1, "R8");
      for (int i = 0; i < 4; i++) send(8'h00, 0, 0, 0, 0, "R6");
      wait (q.size() == 0);
      @(posedge clk); #2;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule